// File: doc/BRIEF.md
# Narrow Static RAM Width Adapter

This block sits between a 32-bit single-request processor bus and a 16-bit asynchronous static RAM. It decodes each request address into one of four banks. Each bank has its own base, size and a width-matching switch. A request that hits no bank is answered at once with an error and starts no memory activity.

In a bank with matching on, every access runs as two back-to-back 16-bit memory cycles, whatever its size. The first cycle covers the upper halfword and the second covers the lower one. The active-low byte enables make sure a narrow write changes only the lanes it addresses: the cycle that is not needed still runs, but with both enables held high. Reads gather the two halfwords into one 32-bit word, and the bus is acknowledged once, after the second cycle.

In a bank with matching off, each access is a single 16-bit cycle, so a 32-bit write stores only its addressed halfword. Every memory cycle lasts a parameterised number of clocks. Write enable is released one clock before the cycle ends, so that address and data are held past the write strobe.

Top module: `sram_width_adapter`

## Requirements
- R1: Banks decode as 0x80000000 (2 MiB, matched), 0x80200000 (2 MiB, matched), 0xFF000000 (8 MiB, not matched) and 0xFF800000 (8 MiB, not matched). During an access only `mem_ce_n[i]` of the hit bank i is low, and no chip enable is low when idle.
- R2: A request outside every bank is acknowledged one clock after it is accepted, with `bus_err` high. No chip enable goes low for it.
- R3: In a matched bank every access runs exactly two memory cycles. The first is at the even halfword address `{offset[..:2],0}` and the second at that address plus one. `bus_ack` rises 2*WAIT_CYC+1 clocks after the accepting edge.
- R4: A halfword write in a matched bank holds `mem_be_n` = 2'b11 during the cycle that covers the other halfword, and 2'b00 during its own cycle.
- R5: A byte write in a matched bank lowers only the enable of its lane, and only in the cycle covering that byte. The other three bytes of the word keep their values.
- R6: In a bank with matching off, an access is one memory cycle and `bus_ack` rises WAIT_CYC+1 clocks after acceptance. A 32-bit write stores only bus bytes 0-1, and the other halfword stays unchanged.
- R7: Each memory cycle keeps chip enable, address and data steady for WAIT_CYC clocks. For writes, `mem_we_n` is low for the first WAIT_CYC-1 of those clocks and high in the last one. Output enable and write enable are never low together.
- R8: A read in a matched bank returns {first halfword, second halfword} on `bus_rdata` together with a single one-clock `bus_ack`. Both byte enables are low during read cycles.
- R9: A read in a bank with matching off returns the addressed halfword in both halves of `bus_rdata`.
- R10: While an access is in progress, and in its acknowledge clock, `bus_req` is ignored. A request made then produces no ack and no memory cycle.
- R11: Byte order is big-endian. Bus byte k (address offset k) travels on `bus_wdata[31-8k -: 8]`. `mem_be_n[1]` gates `mem_dout[15:8]`, the even byte, and `mem_be_n[0]` gates `mem_dout[7:0]`. `bus_size` encodes 0 = byte, 1 = halfword, 2 = word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-clock request pulse, accepted only when idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data, lane-aligned big-endian |
| bus_ack | output | 1 | One-clock completion strobe |
| bus_err | output | 1 | Address decode error, valid with bus_ack |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| mem_ce_n | output | NBANK | Active-low chip enable per bank |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 2 | Active-low byte enables |
| mem_addr | output | MEM_AW | Halfword address within the bank |
| mem_dout | output | 16 | Write data to memory |
| mem_dq_en | output | 1 | High while the adapter drives mem_dout |
| mem_din | input | 16 | Read data from memory |

## Verification
An access is accepted on the clock edge where `bus_req` is seen idle. The ack is due on edge 2*WAIT_CYC+1 for a matched bank, edge WAIT_CYC+1 for an unmatched bank and edge 1 for a decode error, counting the accepting edge as 1. The bench counts posedges from the accepting edge and samples on the following falling edges. Every latency is compared against those figures. Write strobes, byte enables, addresses and data are logged on the falling edge where `mem_we_n` first goes low in each cycle, after all registers have settled. Ignored-request and untouched-lane cases are checked by reading the affected words back over the bus.

// File: rtl/sram_adapt_pkg.sv
package sram_adapt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  // Byte lanes touched by an access; bit k stands for address offset k.
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] a);
    case (size)
      2'd0:    lane_mask = 4'b0001 << a;
      2'd1:    lane_mask = a[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // Active-low enables for the memory cycle covering halfword hsel.
  function automatic logic [1:0] cycle_be_n(input logic [3:0] mask, input logic hsel);
    cycle_be_n = ~{mask[{hsel, 1'b0}], mask[{hsel, 1'b1}]};
  endfunction

  // Halfword of the bus word carried by the memory cycle hsel.
  function automatic logic [15:0] cycle_data(input logic [31:0] w, input logic hsel);
    cycle_data = hsel ? w[15:0] : w[31:16];
  endfunction

  function automatic logic in_window(input logic [31:0] addr, input logic [31:0] base,
                                     input logic [4:0] asz);
    logic [31:0] keep;
    keep = ~((32'h1 << asz) - 32'h1);
    in_window = (addr & keep) == (base & keep);
  endfunction

endpackage

// File: rtl/bank_decoder.sv
module bank_decoder
  import sram_adapt_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW = 2,
  parameter int MEM_AW = 22,
  parameter logic [NBANK-1:0][31:0] BASE = '0,
  parameter logic [NBANK-1:0][4:0]  ASZ  = '0,
  parameter logic [NBANK-1:0]       MATCH = '0
) (
  input  logic [31:0]       addr,
  output logic              hit,
  output logic [BW-1:0]     idx,
  output logic              matched,
  output logic [MEM_AW-1:0] hw_off
);
  logic [NBANK-1:0]             hit_vec;
  logic [NBANK-1:0][MEM_AW-1:0] off_vec;

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_win
    assign hit_vec[gi] = in_window(addr, BASE[gi], ASZ[gi]);
    assign off_vec[gi] = MEM_AW'((addr & ((32'h1 << ASZ[gi]) - 32'h1)) >> 1);
  end

  // Lowest numbered bank wins on overlap.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    matched = 1'b0;
    hw_off = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit = 1'b1;
        idx = BW'(i);
        matched = MATCH[i];
        hw_off = off_vec[i];
      end
    end
  end
endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
  import sram_adapt_pkg::*;
#(
  parameter int WAIT_CYC = 3,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          hit,
  input  logic          matched,
  input  logic [BW-1:0] idx,
  input  logic          we,
  output logic          accept,
  output logic          busy,
  output logic          cyc,
  output logic          last_clk,
  output logic          cycle_end,
  output logic          done,
  output logic          err,
  output logic          matched_q,
  output logic          we_q,
  output logic [BW-1:0] bank_q
);
  localparam int WCW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [WCW-1:0] WLAST = WCW'(WAIT_CYC - 1);

  seq_state_e     state;
  logic [WCW-1:0] wcnt;
  logic           err_q;

  assign accept    = (state == ST_IDLE) && req;
  assign busy      = (state == ST_RUN);
  assign last_clk  = busy && (wcnt == WLAST);
  assign cycle_end = last_clk;
  assign done      = (state == ST_DONE);
  assign err       = done && err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wcnt <= '0;
      cyc <= 1'b0;
      err_q <= 1'b0;
      matched_q <= 1'b0;
      we_q <= 1'b0;
      bank_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req) begin
            wcnt <= '0;
            cyc <= 1'b0;
            err_q <= !hit;
            matched_q <= matched;
            we_q <= we;
            bank_q <= idx;
            state <= hit ? ST_RUN : ST_DONE;
          end
        end
        ST_RUN: begin
          if (wcnt == WLAST) begin
            wcnt <= '0;
            if (matched_q && !cyc) cyc <= 1'b1;
            else state <= ST_DONE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_gen.sv
module lane_gen
  import sram_adapt_pkg::*;
(
  input  logic        active,
  input  logic        we,
  input  logic        hsel,
  input  logic [3:0]  mask,
  input  logic [31:0] wdata,
  output logic [1:0]  be_n,
  output logic [15:0] dout
);
  always_comb begin
    if (!active)  be_n = 2'b11;
    else if (!we) be_n = 2'b00;
    else          be_n = cycle_be_n(mask, hsel);
  end
  assign dout = cycle_data(wdata, hsel);
endmodule

// File: rtl/read_assembler.sv
module read_assembler (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap,
  input  logic        matched,
  input  logic        hsel,
  input  logic [15:0] din,
  output logic [31:0] rdata
);
  logic [15:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (cap) begin
      if (!matched) begin
        hi_q <= din;
        lo_q <= din;
      end else if (hsel) begin
        lo_q <= din;
      end else begin
        hi_q <= din;
      end
    end
  end
  assign rdata = {hi_q, lo_q};
endmodule

// File: rtl/sram_width_adapter.sv
module sram_width_adapter
  import sram_adapt_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int MEM_AW = 22,
  parameter int WAIT_CYC = 3,
  parameter logic [NBANK-1:0][31:0] BANK_BASE =
    {32'hFF80_0000, 32'hFF00_0000, 32'h8020_0000, 32'h8000_0000},
  parameter logic [NBANK-1:0][4:0] BANK_ASZ = {5'd23, 5'd23, 5'd21, 5'd21},
  parameter logic [NBANK-1:0] BANK_MATCH = 4'b0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [31:0]       bus_rdata,
  output logic [NBANK-1:0]  mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [1:0]        mem_be_n,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [15:0]       mem_dout,
  output logic              mem_dq_en,
  input  logic [15:0]       mem_din
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;

  // Named internal events, also observed by the checker.
  logic              dec_hit, dec_matched;
  logic [BW-1:0]     dec_idx;
  logic [MEM_AW-1:0] dec_hw_off;
  logic              seq_accept, seq_busy, seq_cyc, seq_last_clk, seq_cycle_end;
  logic              seq_done, seq_err, seq_matched, seq_we;
  logic [BW-1:0]     seq_bank;
  logic              seq_hsel;

  logic [MEM_AW-1:0] hw_off_q;
  logic              a1_q;
  logic [3:0]        mask_q;
  logic [31:0]       wdata_q;

  bank_decoder #(
    .NBANK(NBANK), .BW(BW), .MEM_AW(MEM_AW),
    .BASE(BANK_BASE), .ASZ(BANK_ASZ), .MATCH(BANK_MATCH)
  ) u_dec (
    .addr(bus_addr), .hit(dec_hit), .idx(dec_idx),
    .matched(dec_matched), .hw_off(dec_hw_off)
  );

  cycle_sequencer #(.WAIT_CYC(WAIT_CYC), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .hit(dec_hit),
    .matched(dec_matched), .idx(dec_idx), .we(bus_we),
    .accept(seq_accept), .busy(seq_busy), .cyc(seq_cyc),
    .last_clk(seq_last_clk), .cycle_end(seq_cycle_end), .done(seq_done),
    .err(seq_err), .matched_q(seq_matched), .we_q(seq_we), .bank_q(seq_bank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_off_q <= '0;
      a1_q <= 1'b0;
      mask_q <= '0;
      wdata_q <= '0;
    end else if (seq_accept) begin
      hw_off_q <= dec_hw_off;
      a1_q <= bus_addr[1];
      mask_q <= lane_mask(bus_size, bus_addr[1:0]);
      wdata_q <= bus_wdata;
    end
  end

  // Matched banks step through both halves; others use the addressed one.
  assign seq_hsel = seq_matched ? seq_cyc : a1_q;
  assign mem_addr = seq_matched ? {hw_off_q[MEM_AW-1:1], seq_cyc} : hw_off_q;

  lane_gen u_lane (
    .active(seq_busy), .we(seq_we), .hsel(seq_hsel), .mask(mask_q),
    .wdata(wdata_q), .be_n(mem_be_n), .dout(mem_dout)
  );

  read_assembler u_rd (
    .clk(clk), .rst_n(rst_n), .cap(seq_cycle_end && !seq_we),
    .matched(seq_matched), .hsel(seq_hsel), .din(mem_din), .rdata(bus_rdata)
  );

  assign mem_ce_n  = ~(seq_busy ? (NBANK'(1) << seq_bank) : NBANK'(0));
  assign mem_we_n  = ~(seq_busy && seq_we && !seq_last_clk);
  assign mem_oe_n  = ~(seq_busy && !seq_we);
  assign mem_dq_en = seq_busy && seq_we;
  assign bus_ack   = seq_done;
  assign bus_err   = seq_err;
endmodule

// File: rtl/sram_adapter_checker.sv
module sram_adapter_checker #(
  parameter int NBANK = 4,
  parameter int MEM_AW = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ack,
  input logic              bus_err,
  input logic [NBANK-1:0]  mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [1:0]        mem_be_n,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              seq_busy,
  input logic              seq_accept
);
  assert_ce_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n));

  assert_err_has_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ack);

  assert_err_no_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && bus_err) |-> $past(&mem_ce_n));

  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  assert_we_early_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&mem_ce_n && !$past(&mem_ce_n)) |-> $past(mem_we_n));

  assert_we_inside_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !(&mem_ce_n));

  assert_no_oe_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  assert_read_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_be_n == 2'b00));

  assert_busy_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy || bus_ack) |-> !seq_accept);
endmodule

bind sram_width_adapter sram_adapter_checker #(.NBANK(NBANK), .MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ack(bus_ack), .bus_err(bus_err),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_be_n(mem_be_n), .mem_addr(mem_addr), .seq_busy(seq_busy),
  .seq_accept(seq_accept)
);

// File: tb/tb_sram_width_adapter.sv
`timescale 1ns/1ps
module tb_sram_width_adapter;
  localparam int W = 3;
  localparam int AW = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [1:0] bus_size = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic bus_ack, bus_err;
  logic [31:0] bus_rdata;
  logic [3:0] mem_ce_n;
  logic mem_we_n, mem_oe_n, mem_dq_en;
  logic [1:0] mem_be_n;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_dout;
  logic [15:0] mem_din = 0;

  always #2 clk = ~clk;

  sram_width_adapter #(.WAIT_CYC(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dq_en(mem_dq_en), .mem_din(mem_din)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Static RAM model, one 16-bit word per {bank, halfword address}.
  logic [15:0] sram_m [int];
  function automatic int mkey(input int b, input logic [AW-1:0] a);
    return (b << 24) | int'(a);
  endfunction
  function automatic int active_bank();
    for (int b = 0; b < 4; b++) if (!mem_ce_n[b]) return b;
    return -1;
  endfunction

  always @(posedge clk) begin
    int b, k;
    logic [15:0] v;
    b = active_bank();
    if (b >= 0 && !mem_we_n) begin
      k = mkey(b, mem_addr);
      v = sram_m.exists(k) ? sram_m[k] : 16'h0;
      if (!mem_be_n[1]) v[15:8] = mem_dout[15:8];
      if (!mem_be_n[0]) v[7:0] = mem_dout[7:0];
      sram_m[k] = v;
    end
  end

  // Monitor: read data drive and write-cycle logging on falling edges.
  int wr_cnt, ce_clks, we_clks, ack_cnt;
  logic [3:0] ce_seen;
  logic [1:0] be_log [4];
  logic [AW-1:0] addr_log [4];
  logic [15:0] dout_log [4];
  logic we_prev = 1'b1;
  always @(negedge clk) begin
    int b, k;
    b = active_bank();
    if (b >= 0 && !mem_oe_n) begin
      k = mkey(b, mem_addr);
      mem_din = sram_m.exists(k) ? sram_m[k] : 16'h0;
    end
    if (!mem_we_n && we_prev) begin
      if (wr_cnt < 4) begin
        be_log[wr_cnt] = mem_be_n;
        addr_log[wr_cnt] = mem_addr;
        dout_log[wr_cnt] = mem_dout;
      end
      wr_cnt++;
    end
    we_prev = mem_we_n;
    if (~&mem_ce_n) begin
      ce_clks++;
      ce_seen |= ~mem_ce_n;
    end
    if (!mem_we_n) we_clks++;
    if (bus_ack) ack_cnt++;
  end

  // Reference byte store built from the requirements.
  logic [7:0] refb [int];
  function automatic logic [7:0] rb(input logic [31:0] a);
    return refb.exists(int'(a)) ? refb[int'(a)] : 8'h0;
  endfunction
  function automatic bit is_matched(input logic [31:0] a);
    return a >= 32'h8000_0000 && a < 32'h8040_0000;
  endfunction

  logic [31:0] got_rdata;
  logic got_err;
  int lat;

  task automatic do_access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                           input logic [31:0] wd, input bit inject);
    wr_cnt = 0; ce_clks = 0; we_clks = 0; ack_cnt = 0; ce_seen = '0; lat = 0;
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (inject && lat == 2) begin
        bus_req = 1; bus_we = 1; bus_size = 2; bus_addr = 32'h8020_0040;
        bus_wdata = 32'hDEAD_BEEF;
      end else begin
        bus_req = 0;
      end
      if (bus_ack) begin
        got_rdata = bus_rdata;
        got_err = bus_err;
        break;
      end
      if (lat > 40) break;
    end
    if (inject) begin
      bus_req = 1; bus_we = 1; bus_size = 2; bus_addr = 32'h8020_0040;
    end
    @(negedge clk);
    bus_req = 0;
    repeat (6) @(negedge clk);
    if (we && !got_err) begin
      int off, nb;
      logic [31:0] wa;
      off = int'(a[1:0]);
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      wa = {a[31:2], 2'b00};
      for (int k = 0; k < 4; k++) begin
        bit in_acc;
        in_acc = (k >= off) && (k < off + nb);
        if (!is_matched(a)) in_acc = in_acc && ((k / 2) == int'(a[1]));
        if (in_acc) refb[int'(wa + 32'(k))] = wd[31 - 8*k -: 8];
      end
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [31:0] a);
    logic [31:0] wa, ha;
    wa = {a[31:2], 2'b00};
    ha = {a[31:1], 1'b0};
    if (is_matched(a)) return {rb(wa), rb(wa + 1), rb(wa + 2), rb(wa + 3)};
    return {rb(ha), rb(ha + 1), rb(ha), rb(ha + 1)};
  endfunction

  task automatic read_check(input string tag, input logic [1:0] sz, input logic [31:0] a);
    do_access(0, sz, a, 32'h0, 0);
    chk({tag, " read data"}, got_rdata, exp_read(a));
    chk({tag, " read latency"}, 32'(lat), is_matched(a) ? 32'(2*W+1) : 32'(W+1));
    chk({tag, " read has no write strobe"}, 32'(wr_cnt), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset chip enables high", 32'(mem_ce_n), 32'hF);
    chk("R7 reset write enable high", 32'(mem_we_n), 1);
    chk("R7 reset output enable high", 32'(mem_oe_n), 1);
    chk("R8 reset no ack", 32'(bus_ack), 0);
  endtask

  task automatic t_word_matched();
    do_access(1, 2, 32'h8000_0000, 32'h1122_3344, 0);
    chk("R3 word write latency", 32'(lat), 32'(2*W+1));
    chk("R3 word write cycle count", 32'(wr_cnt), 2);
    chk("R3 first cycle even address", 32'(addr_log[0]), 0);
    chk("R3 second cycle address plus one", 32'(addr_log[1]), 1);
    chk("R11 first cycle carries bytes 0-1", 32'(dout_log[0]), 32'h1122);
    chk("R11 second cycle carries bytes 2-3", 32'(dout_log[1]), 32'h3344);
    chk("R11 word lanes cycle 0", 32'(be_log[0]), 0);
    chk("R11 word lanes cycle 1", 32'(be_log[1]), 0);
    chk("R1 bank 0 chip enable only", 32'(ce_seen), 32'h1);
    chk("R7 chip enable clocks", 32'(ce_clks), 32'(2*W));
    chk("R7 write strobe clocks", 32'(we_clks), 32'(2*(W-1)));
    read_check("R8 word", 2, 32'h8000_0000);
  endtask

  task automatic t_half_matched();
    do_access(1, 1, 32'h8000_0002, 32'h0000_AABB, 0);
    chk("R3 halfword write two cycles", 32'(wr_cnt), 2);
    chk("R4 low half: upper cycle disabled", 32'(be_log[0]), 32'h3);
    chk("R4 low half: own cycle enabled", 32'(be_log[1]), 0);
    read_check("R4 low half kept upper", 2, 32'h8000_0000);
    do_access(1, 1, 32'h8000_0004, 32'hCCDD_0000, 0);
    chk("R4 high half: own cycle enabled", 32'(be_log[0]), 0);
    chk("R4 high half: lower cycle disabled", 32'(be_log[1]), 32'h3);
    chk("R3 addresses 2 then 3", 32'({addr_log[0], addr_log[1]}), 32'({22'd2, 22'd3}));
    read_check("R4 high half", 2, 32'h8000_0004);
  endtask

  task automatic t_byte_matched();
    do_access(1, 2, 32'h8020_0000, 32'h5566_7788, 0);
    do_access(1, 0, 32'h8020_0001, 32'h00EE_0000, 0);
    chk("R5 byte write two cycles", 32'(wr_cnt), 2);
    chk("R5 byte 1 lane in first cycle", 32'(be_log[0]), 32'h2);
    chk("R5 byte 1 second cycle disabled", 32'(be_log[1]), 32'h3);
    chk("R1 bank 1 chip enable only", 32'(ce_seen), 32'h2);
    read_check("R5 byte 1 neighbours kept", 2, 32'h8020_0000);
    do_access(1, 0, 32'h8020_0003, 32'h0000_0099, 0);
    chk("R5 byte 3 first cycle disabled", 32'(be_log[0]), 32'h3);
    chk("R5 byte 3 lane in second cycle", 32'(be_log[1]), 32'h2);
    read_check("R5 byte 3", 2, 32'h8020_0000);
    chk("R5 assembled value", got_rdata, 32'h55EE_7799);
  endtask

  task automatic t_unmatched();
    do_access(1, 2, 32'hFF00_0010, 32'hA1B2_C3D4, 0);
    chk("R6 one write cycle", 32'(wr_cnt), 1);
    chk("R6 write latency", 32'(lat), 32'(W+1));
    chk("R6 chip enable clocks", 32'(ce_clks), 32'(W));
    chk("R1 bank 2 chip enable only", 32'(ce_seen), 32'h4);
    chk("R6 stored bytes 0-1", 32'(dout_log[0]), 32'hA1B2);
    read_check("R9 word replicated", 2, 32'hFF00_0010);
    read_check("R6 lower halfword not stored", 1, 32'hFF00_0012);
    chk("R6 lower halfword still zero", got_rdata, 32'h0);
    do_access(1, 1, 32'hFFFF_FFFE, 32'h0000_BEEF, 0);
    chk("R1 bank 3 top address", 32'(ce_seen), 32'h8);
    chk("R6 halfword lanes", 32'(be_log[0]), 0);
    read_check("R9 bank 3 top halfword", 1, 32'hFFFF_FFFE);
    chk("R9 replicated value", got_rdata, 32'hBEEF_BEEF);
  endtask

  task automatic t_error();
    do_access(1, 2, 32'h8040_0000, 32'h1234_5678, 0);
    chk("R2 error flag above bank 1", 32'(got_err), 1);
    chk("R2 error latency", 32'(lat), 1);
    chk("R2 no chip enable", 32'(ce_clks), 0);
    do_access(0, 2, 32'h7FFF_FFFC, 32'h0, 0);
    chk("R2 error flag below bank 0", 32'(got_err), 1);
    do_access(0, 2, 32'h803F_FFFC, 32'h0, 0);
    chk("R1 last word of bank 1 decodes", 32'(got_err), 0);
    chk("R1 last word bank 1 enable", 32'(ce_seen), 32'h2);
  endtask

  task automatic t_busy();
    do_access(0, 2, 32'h8000_0000, 32'h0, 1);
    chk("R10 single ack", 32'(ack_cnt), 1);
    chk("R10 only bank 0 enabled", 32'(ce_seen), 32'h1);
    chk("R10 no write cycle", 32'(wr_cnt), 0);
    read_check("R10 ignored write left memory", 2, 32'h8020_0040);
    chk("R10 target still zero", got_rdata, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_word_matched();
    t_half_matched();
    t_byte_matched();
    t_unmatched();
    t_error();
    t_busy();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule